// File: doc/BRIEF.md
# Timing-Path Loop Mode Sequencer

This block decides which of three operating modes a telecom digital phase-locked loop path runs in: Free-Run (no reference in use), Locked (tracking a selected input clock) or Holdover (coasting after losing its reference). The reference-selection logic in the same path reports selection events to the block. The block turns those events into a registered mode that the loop filter and its status logic read.

A 3-bit mode control input can pin the path to one mode. When it holds the automatic code, a small state machine moves between the modes on selection events. Four switch causes can each push a Locked path into Holdover, and they arrive on a cause vector:
- the selected clock was disqualified,
- a higher-priority qualified clock took over,
- a forced reselection happened,
- the reference was moved by toggling the bit that makes this path follow the other path's loop output.

A sticky, enable-gated interrupt flag records every mode change until software clears it with a one-cycle pulse.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the mode status reads Free-Run (001) and the interrupt flag reads 0.
- R2: Mode control codes 001, 010 and 100 force Free-Run, Holdover and Locked respectively. The status shows the forced mode from the first rising edge that samples the code.
- R3: Code 000 selects automatic sequencing, and every other code (011, 101, 110, 111) is handled the same as 000.
- R4: In automatic operation in Free-Run, a pulse on `ref_sel_evt` moves the mode to Locked on the next edge.
- R5: In automatic operation in Locked, a pulse on any bit of `sw_cause` moves the mode to Holdover on the next edge. The bits are [0] disqualified, [1] revertive priority switch, [2] forced reselection and [3] cross-path reference toggle. Several bits in one cycle cause a single transition.
- R6: In automatic operation in Holdover, a pulse on `ref_sel_evt` moves the mode back to Locked, even when `no_ref` is high in the same cycle.
- R7: In automatic operation in Holdover, `no_ref` high without `ref_sel_evt` moves the mode to Free-Run.
- R8: In automatic operation, every other input combination leaves the mode unchanged. This covers causes seen in Free-Run or Holdover and `no_ref` seen in Free-Run or Locked. When automatic operation resumes after a forced code, it starts from the mode that was forced.
- R9: The status output always uses the one-hot encoding 001 Free-Run, 010 Holdover, 100 Locked.
- R10: The interrupt flag is set after any cycle in which the mode changes while `irq_en` is high. A change while `irq_en` is low does not set it.
- R11: A pulse on `irq_clr` clears the flag. If a set and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_cfg | input | 3 | Mode control code |
| ref_sel_evt | input | 1 | Pulse: an input clock has been selected |
| no_ref | input | 1 | Level: no input clock is currently selected |
| sw_cause | input | NUM_CAUSE | Pulses: reasons the selected clock was switched away |
| irq_en | input | 1 | Enables setting of the interrupt flag |
| irq_clr | input | 1 | Write-one-to-clear pulse for the flag |
| mode_sts | output | 3 | Current operating mode, one-hot |
| mode_irq | output | 1 | Sticky mode-change interrupt flag |

## Verification
Random stimulus mostly holds the automatic code, with sparse event pulses, so the machine walks all three modes many times. The same stimulus also offers each mode the events it must ignore, which tells genuine transitions apart from spurious ones. Randomly interleaved forced and illegal codes separate the forcing path from the automatic path, and show whether automatic operation resumes from the forced mode. Directed cycles cover the remaining corners:
- all four causes in one cycle,
- a selection and loss of reference together in Holdover,
- a set and a clear of the interrupt in the same cycle,
- mode changes while the interrupt is disabled.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_FREE = 3'b001,
    MODE_HOLD = 3'b010,
    MODE_LOCK = 3'b100
  } mode_e;

  localparam logic [MODE_W-1:0] CFG_AUTO = 3'b000;

  // True when the control code pins the path to one mode.
  function automatic logic cfg_is_forced(input logic [MODE_W-1:0] code);
    return (code == 3'b001) || (code == 3'b010) || (code == 3'b100);
  endfunction

  // Mode that a forced control code requests.
  function automatic mode_e cfg_mode(input logic [MODE_W-1:0] code);
    case (code)
      3'b010:  return MODE_HOLD;
      3'b100:  return MODE_LOCK;
      default: return MODE_FREE;
    endcase
  endfunction

  // Automatic sequencing step.
  function automatic mode_e auto_step(input mode_e cur, input logic sel,
                                      input logic none, input logic cause);
    mode_e nxt;
    nxt = cur;
    case (cur)
      MODE_FREE: if (sel) nxt = MODE_LOCK;
      MODE_LOCK: if (cause) nxt = MODE_HOLD;
      MODE_HOLD: begin
        if (sel)       nxt = MODE_LOCK;
        else if (none) nxt = MODE_FREE;
      end
      default:   nxt = MODE_FREE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/dmc_cfg_decode.sv
module dmc_cfg_decode
  import dmc_pkg::*;
(
  input  logic [MODE_W-1:0] mode_cfg,
  output logic              cfg_forced,
  output mode_e             cfg_target
);
  always_comb begin
    cfg_forced = cfg_is_forced(mode_cfg);
    cfg_target = cfg_mode(mode_cfg);
  end
endmodule

// File: rtl/dmc_cause_merge.sv
module dmc_cause_merge #(
  parameter int NUM_CAUSE = 4
) (
  input  logic [NUM_CAUSE-1:0] cause,
  output logic                 any_cause
);
  logic [NUM_CAUSE:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_or
    assign chain[i+1] = chain[i] | cause[i];
  end
  assign any_cause = chain[NUM_CAUSE];
endmodule

// File: rtl/dmc_mode_fsm.sv
module dmc_mode_fsm
  import dmc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cfg_forced,
  input  mode_e cfg_target,
  input  logic  sel_evt,
  input  logic  none_sel,
  input  logic  any_cause,
  output mode_e mode_q,
  output mode_e mode_nxt,
  output logic  mode_chg
);
  always_comb begin
    if (cfg_forced) mode_nxt = cfg_target;
    else            mode_nxt = auto_step(mode_q, sel_evt, none_sel, any_cause);
    mode_chg = (mode_nxt != mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_FREE;
    else        mode_q <= mode_nxt;
  end
endmodule

// File: rtl/dmc_irq_flag.sv
module dmc_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_evt) flag_q <= 1'b0;
  end
endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
  import dmc_pkg::*;
#(
  parameter int NUM_CAUSE = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           mode_cfg,
  input  logic                 ref_sel_evt,
  input  logic                 no_ref,
  input  logic [NUM_CAUSE-1:0] sw_cause,
  input  logic                 irq_en,
  input  logic                 irq_clr,
  output logic [2:0]           mode_sts,
  output logic                 mode_irq
);
  logic  cfg_forced;
  mode_e cfg_target;
  logic  any_cause;
  mode_e mode_q;
  mode_e mode_nxt;
  logic  mode_chg;
  logic  irq_set;

  dmc_cfg_decode u_dec (
    .mode_cfg  (mode_cfg),
    .cfg_forced(cfg_forced),
    .cfg_target(cfg_target)
  );

  dmc_cause_merge #(.NUM_CAUSE(NUM_CAUSE)) u_merge (
    .cause    (sw_cause),
    .any_cause(any_cause)
  );

  dmc_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_forced(cfg_forced),
    .cfg_target(cfg_target),
    .sel_evt   (ref_sel_evt),
    .none_sel  (no_ref),
    .any_cause (any_cause),
    .mode_q    (mode_q),
    .mode_nxt  (mode_nxt),
    .mode_chg  (mode_chg)
  );

  assign irq_set = mode_chg & irq_en;

  dmc_irq_flag u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_evt(irq_set),
    .clr_evt(irq_clr),
    .flag_q (mode_irq)
  );

  assign mode_sts = mode_q;
endmodule

// File: rtl/dmc_mode_checker.sv
module dmc_mode_checker #(
  parameter int NUM_CAUSE = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           mode_cfg,
  input logic                 ref_sel_evt,
  input logic                 no_ref,
  input logic [NUM_CAUSE-1:0] sw_cause,
  input logic                 irq_clr,
  input logic [2:0]           mode_sts,
  input logic                 mode_irq,
  input logic                 irq_set
);
  logic forced_c;
  logic auto_c;
  assign forced_c = (mode_cfg == 3'b001) || (mode_cfg == 3'b010) || (mode_cfg == 3'b100);
  assign auto_c   = !forced_c;

  AST_FORCED_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    forced_c |=> mode_sts == $past(mode_cfg)); // R2
  AST_FREE_TO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    auto_c && mode_sts == 3'b001 && ref_sel_evt |=> mode_sts == 3'b100); // R4
  AST_LOCK_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    auto_c && mode_sts == 3'b100 && (|sw_cause) |=> mode_sts == 3'b010); // R5
  AST_HOLD_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
    auto_c && mode_sts == 3'b010 && ref_sel_evt |=> mode_sts == 3'b100); // R6
  AST_HOLD_TO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    auto_c && mode_sts == 3'b010 && no_ref && !ref_sel_evt |=> mode_sts == 3'b001); // R7
  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    auto_c && !ref_sel_evt && !no_ref && !(|sw_cause) |=> $stable(mode_sts)); // R8
  AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_sts) == 1); // R9
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> mode_irq); // R10
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr && !irq_set |=> !mode_irq); // R11
endmodule

bind dpll_mode_ctrl dmc_mode_checker #(.NUM_CAUSE(NUM_CAUSE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_cfg   (mode_cfg),
  .ref_sel_evt(ref_sel_evt),
  .no_ref     (no_ref),
  .sw_cause   (sw_cause),
  .irq_clr    (irq_clr),
  .mode_sts   (mode_sts),
  .mode_irq   (mode_irq),
  .irq_set    (irq_set)
);

// File: tb/dpll_mode_ctrl_tb.sv
module dpll_mode_ctrl_tb;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    mode_cfg = 3'b000;
  logic          ref_sel_evt = 1'b0;
  logic          no_ref = 1'b0;
  logic [NC-1:0] sw_cause = '0;
  logic          irq_en = 1'b0;
  logic          irq_clr = 1'b0;
  logic [2:0]    mode_sts;
  logic          mode_irq;

  int total = 0;
  int bad = 0;
  logic [2:0] exp_mode = 3'b001;
  logic       exp_irq = 1'b0;
  string      mode_tag = "R1";
  string      irq_tag = "R1";

  always #4 clk = ~clk;

  dpll_mode_ctrl #(.NUM_CAUSE(NC)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .ref_sel_evt(ref_sel_evt),
    .no_ref(no_ref), .sw_cause(sw_cause), .irq_en(irq_en), .irq_clr(irq_clr),
    .mode_sts(mode_sts), .mode_irq(mode_irq)
  );

  // Reference model, written from the requirement list.
  function automatic logic [2:0] ref_next(input logic [2:0] cur, input logic [2:0] cfg,
                                          input logic sel, input logic none,
                                          input logic [NC-1:0] cs);
    if (cfg == 3'b001 || cfg == 3'b010 || cfg == 3'b100) return cfg;  // R2
    if (cur == 3'b001) return sel ? 3'b100 : cur;                     // R4
    if (cur == 3'b100) return (cs != 0) ? 3'b010 : cur;               // R5
    if (sel) return 3'b100;                                           // R6
    if (none) return 3'b001;                                          // R7
    return cur;
  endfunction

  function automatic string pick_tag(input logic [2:0] cur, input logic [2:0] cfg,
                                     input logic [2:0] nxt);
    if (cfg == 3'b001 || cfg == 3'b010 || cfg == 3'b100) return "R2";
    if (cfg != 3'b000) return "R3";
    if (nxt == cur) return "R8";
    if (cur == 3'b001) return "R4";
    if (cur == 3'b100) return "R5";
    if (nxt == 3'b100) return "R6";
    return "R7";
  endfunction

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: check outputs at the falling edge, then drive and advance the model.
  task automatic step(input logic [2:0] cfg, input logic sel, input logic none,
                      input logic [NC-1:0] cs, input logic en, input logic clr);
    logic [2:0] nxt;
    @(negedge clk);
    check(mode_tag, mode_sts, exp_mode);
    check(irq_tag, {2'b00, mode_irq}, {2'b00, exp_irq});
    check("R9", 3'(($countones(mode_sts) == 1) ? 1 : 0), 3'd1);
    mode_cfg = cfg; ref_sel_evt = sel; no_ref = none; sw_cause = cs;
    irq_en = en; irq_clr = clr;
    nxt = ref_next(exp_mode, cfg, sel, none, cs);
    mode_tag = pick_tag(exp_mode, cfg, nxt);
    if (nxt != exp_mode && en) begin
      exp_irq = 1'b1; irq_tag = "R10";
    end else if (clr) begin
      exp_irq = 1'b0; irq_tag = "R11";
    end else begin
      irq_tag = (nxt != exp_mode) ? "R10" : "R11";
    end
    exp_mode = nxt;
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", mode_sts, 3'b001);
    check("R1", {2'b00, mode_irq}, 3'b000);
    rst_n = 1'b1;
    // Directed corners
    step(3'b000, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0);  // first cycle after reset R1
    step(3'b000, 1'b0, 1'b1, 4'hF, 1'b1, 1'b0);  // R8 ignored in Free-Run
    step(3'b000, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0);  // R4 lock, irq disabled R10
    step(3'b000, 1'b0, 1'b1, 4'h0, 1'b1, 1'b0);  // R8 no_ref ignored in Locked
    step(3'b000, 1'b0, 1'b0, 4'hF, 1'b1, 1'b0);  // R5 all causes together
    step(3'b000, 1'b1, 1'b1, 4'h0, 1'b1, 1'b1);  // R6 relock wins, set beats clear R11
    step(3'b000, 1'b0, 1'b0, 4'h8, 1'b1, 1'b0);  // R5 cross-path toggle only
    step(3'b000, 1'b0, 1'b1, 4'h0, 1'b0, 1'b1);  // R7 free, clear R11
    step(3'b110, 1'b1, 1'b0, 4'h0, 1'b1, 1'b0);  // R3 illegal code acts automatic
    step(3'b010, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0);  // R2 forced holdover
    step(3'b000, 1'b0, 1'b1, 4'h0, 1'b1, 1'b0);  // R8 resume from forced: to Free
    step(3'b100, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1);  // R2 forced locked
    step(3'b000, 1'b0, 1'b0, 4'h2, 1'b1, 1'b0);  // resume from Locked, revertive R5
    // Constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] cfg;
      logic [NC-1:0] cs;
      cfg = ($urandom_range(0, 9) < 7) ? 3'b000 : 3'($urandom_range(0, 7));
      for (int b = 0; b < NC; b++) cs[b] = ($urandom_range(0, 9) == 0);
      step(cfg, $urandom_range(0, 6) == 0, $urandom_range(0, 4) == 0, cs,
           $urandom_range(0, 4) != 0, $urandom_range(0, 9) == 0);
    end
    step(3'b000, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule